// File: doc/BRIEF.md
# Run-Time Width Saturator

This block clamps a wide two's-complement integer into an N-bit field. N is chosen at run time, up to a fixed output width. A mode input selects which range applies. In signed mode the range is -2^(N-1) to 2^(N-1)-1. In unsigned mode it is 0 to 2^N-1. The clamped value goes out in the low N bits of the output word, and every bit above N is zero.

A flag rises whenever the input fell outside the selected range and had to be clamped. It is meant to be ORed into a sticky status bit elsewhere. A width of zero, or a width larger than the output word, is rejected: an error output rises and the result is forced to zero.

The saturation logic itself is combinational. A single output register closes it, so the result for the inputs seen at one rising clock edge is visible after that edge.

Top module: `sat_unit`

## Requirements
- R1: In signed mode (signed_mode = 1) with a legal N, an input greater than 2^(N-1)-1 yields 2^(N-1)-1 and sat_flag = 1.
- R2: In signed mode with a legal N, an input less than -2^(N-1) yields -2^(N-1) as an N-bit pattern (only bit N-1 set) and sat_flag = 1.
- R3: In unsigned mode (signed_mode = 0) with a legal N, an input greater than 2^N-1 yields 2^N-1 and sat_flag = 1.
- R4: In unsigned mode with a legal N, a negative input (din MSB set) yields 0 and sat_flag = 1.
- R5: An input inside the selected range appears on dout as its low N bits, and sat_flag = 0.
- R6: With a legal N, bits N and above of dout are zero in both modes.
- R7: When width_n is 0 or greater than OUT_W, width_err = 1, dout = 0 and sat_flag = 0. Otherwise width_err = 0.
- R8: The outputs are registered. Each output reflects the inputs present at the previous rising clk edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | IN_W (40) | Two's-complement value to clamp |
| width_n | input | NW (6) | Field width N, legal range 1 to OUT_W |
| signed_mode | input | 1 | 1 = signed range, 0 = unsigned range |
| dout | output | OUT_W (32) | Clamped value, zero above bit N-1 |
| sat_flag | output | 1 | Clamping occurred |
| width_err | output | 1 | width_n out of range |

## Verification
Values that land exactly on a range limit, or one step beyond it, are hard to reach from the ports. Uniform 40-bit random inputs almost always saturate, and they say nothing about the exact boundary for the chosen N. The stimulus therefore draws many inputs as offsets of -2 to +2 around the computed limits for the current N and mode. It also covers the two extreme widths: N = 1, where the signed range is only -1 to 0, and N = OUT_W, where the mask covers the whole word.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic {
        RANGE_UNSIGNED = 1'b0,
        RANGE_SIGNED   = 1'b1
    } range_e;
endpackage

// File: rtl/sat_bounds.sv
module sat_bounds #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 32,
    parameter int NW    = $clog2(OUT_W + 1)
) (
    input  logic [NW-1:0]          width_n,
    input  sat_pkg::range_e        range_sel,
    output logic signed [IN_W-1:0] hi_lim,
    output logic signed [IN_W-1:0] lo_lim,
    output logic [OUT_W-1:0]       field_mask,
    output logic                   width_ok
);
    localparam logic signed [IN_W-1:0] ONE = IN_W'(1);

    logic signed [IN_W-1:0] full_pow;
    logic signed [IN_W-1:0] half_pow;
    logic [NW-1:0]          n_less;

    always_comb begin
        width_ok = (width_n != '0) && (int'(width_n) <= OUT_W);
        n_less   = width_n - NW'(1);
        full_pow = ONE <<< width_n;
        half_pow = ONE <<< n_less;
        if (range_sel == sat_pkg::RANGE_SIGNED) begin
            hi_lim = half_pow - ONE;
            lo_lim = -half_pow;
        end else begin
            hi_lim = full_pow - ONE;
            lo_lim = '0;
        end
        field_mask = OUT_W'(full_pow - ONE);
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int IN_W = 40
) (
    input  logic signed [IN_W-1:0] value_in,
    input  logic signed [IN_W-1:0] hi_lim,
    input  logic signed [IN_W-1:0] lo_lim,
    output logic signed [IN_W-1:0] value_out,
    output logic                   clamped
);
    always_comb begin
        if (value_in > hi_lim) begin
            value_out = hi_lim;
            clamped   = 1'b1;
        end else if (value_in < lo_lim) begin
            value_out = lo_lim;
            clamped   = 1'b1;
        end else begin
            value_out = value_in;
            clamped   = 1'b0;
        end
    end
endmodule

// File: rtl/sat_unit.sv
module sat_unit #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 32,
    parameter int NW    = $clog2(OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din,
    input  logic [NW-1:0]    width_n,
    input  logic             signed_mode,
    output logic [OUT_W-1:0] dout,
    output logic             sat_flag,
    output logic             width_err
);
    typedef struct packed {
        logic [OUT_W-1:0] value;
        logic             flag;
        logic             err;
    } out_t;

    sat_pkg::range_e        range_sel;
    logic signed [IN_W-1:0] hi_lim, lo_lim, clamp_val;
    logic [OUT_W-1:0]       field_mask;
    logic                   width_ok, clamped;
    out_t                   res_d, res_q;

    assign range_sel = signed_mode ? sat_pkg::RANGE_SIGNED : sat_pkg::RANGE_UNSIGNED;

    sat_bounds #(.IN_W(IN_W), .OUT_W(OUT_W), .NW(NW)) u_bounds (
        .width_n    (width_n),
        .range_sel  (range_sel),
        .hi_lim     (hi_lim),
        .lo_lim     (lo_lim),
        .field_mask (field_mask),
        .width_ok   (width_ok)
    );

    sat_clamp #(.IN_W(IN_W)) u_clamp (
        .value_in  ($signed(din)),
        .hi_lim    (hi_lim),
        .lo_lim    (lo_lim),
        .value_out (clamp_val),
        .clamped   (clamped)
    );

    always_comb begin
        res_d = '0;
        if (width_ok) begin
            res_d.value = OUT_W'(clamp_val) & field_mask;
            res_d.flag  = clamped;
        end else begin
            res_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign dout      = res_q.value;
    assign sat_flag  = res_q.flag;
    assign width_err = res_q.err;
endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 32,
    parameter int NW    = $clog2(OUT_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  din,
    input logic [NW-1:0]    width_n,
    input logic             signed_mode,
    input logic [OUT_W-1:0] dout,
    input logic             sat_flag,
    input logic             width_err
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7: a rejected width gives a zero result and no flag
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |-> (dout == '0 && !sat_flag));

    // R7: the error follows the width sampled one edge earlier
    a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (width_err == ($past(width_n) == '0 || int'($past(width_n)) > OUT_W)));

    // R6: no bits above the field
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !width_err) |-> ((dout >> $past(width_n)) == '0));

    // R4: negative input in unsigned range clamps to zero
    a_r4_unsigned_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!signed_mode && din[IN_W-1]) && !width_err)
        |-> (dout == '0 && sat_flag));

    // R8: outputs cleared during reset
    a_r8_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (dout == '0 && !sat_flag && !width_err));
endmodule

bind sat_unit sat_unit_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .NW(NW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .width_n     (width_n),
    .signed_mode (signed_mode),
    .dout        (dout),
    .sat_flag    (sat_flag),
    .width_err   (width_err)
);

// File: tb/sat_unit_bench.sv
`timescale 1ns/1ps
module sat_unit_bench;
    localparam int IN_W  = 40;
    localparam int OUT_W = 32;
    localparam int NW    = $clog2(OUT_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IN_W-1:0]  din = '0;
    logic [NW-1:0]    width_n = '0;
    logic             signed_mode = 1'b0;
    logic [OUT_W-1:0] dout;
    logic             sat_flag, width_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sat_unit #(.IN_W(IN_W), .OUT_W(OUT_W), .NW(NW)) u_sat_unit (
        .clk(clk), .rst_n(rst_n), .din(din), .width_n(width_n),
        .signed_mode(signed_mode), .dout(dout), .sat_flag(sat_flag),
        .width_err(width_err)
    );

    function automatic longint sx(input logic [IN_W-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint lim_hi(input int n, input bit sm);
        return sm ? ((64'sd1 <<< (n - 1)) - 1) : ((64'sd1 <<< n) - 1);
    endfunction

    function automatic longint lim_lo(input int n, input bit sm);
        return sm ? -(64'sd1 <<< (n - 1)) : 64'sd0;
    endfunction

    // Expected result; tag names the requirement exercised
    function automatic void model(input logic [IN_W-1:0] d, input int n, input bit sm,
                                  output logic [OUT_W-1:0] ev, output bit ef,
                                  output bit ee, output string tag);
        longint x, v;
        x = sx(d);
        ev = '0; ef = 0; ee = 0;
        if (n < 1 || n > OUT_W) begin
            ee = 1; tag = "R7";
            return;
        end
        v = x;
        if (x > lim_hi(n, sm)) begin
            v = lim_hi(n, sm); ef = 1; tag = sm ? "R1" : "R3";
        end else if (x < lim_lo(n, sm)) begin
            v = lim_lo(n, sm); ef = 1; tag = sm ? "R2" : "R4";
        end else begin
            tag = "R5";
        end
        ev = OUT_W'(v & ((64'sd1 <<< n) - 1));
    endfunction

    // Apply at a falling edge, check at the next falling edge (R8 latency)
    task automatic run(input logic [IN_W-1:0] d, input int n, input bit sm);
        logic [OUT_W-1:0] ev;
        bit ef, ee;
        string tag;
        din = d; width_n = NW'(n); signed_mode = sm;
        @(negedge clk);
        model(d, n, sm, ev, ef, ee, tag);
        n_tests++;
        if (dout !== ev || sat_flag !== ef || width_err !== ee) begin
            n_fail++;
            $display("FAIL %s: din=%h n=%0d sm=%0d actual %h/%b/%b expected %h/%b/%b",
                     tag, d, n, sm, dout, sat_flag, width_err, ev, ef, ee);
        end
        // R6: nothing above bit N-1
        if (!ee) begin
            n_tests++;
            if ((dout >> n) != '0) begin
                n_fail++;
                $display("FAIL R6: n=%0d actual %h expected upper bits 0", n, dout);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        n_tests++;
        if (dout !== '0 || sat_flag !== 1'b0 || width_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: reset actual %h/%b/%b expected 0/0/0", dout, sat_flag, width_err);
        end
        rst_n = 1'b1;

        run(IN_W'(5), 1, 1);                  // R1 at N=1 -> 0
        run(IN_W'(-3), 1, 1);                 // R2 at N=1 -> 1
        run(IN_W'(-1), 1, 1);                 // R5 at N=1
        run(IN_W'(200), 8, 1);                // R1 -> 7f
        run(IN_W'(-129), 8, 1);               // R2 -> 80
        run(IN_W'(-128), 8, 1);               // R5 boundary
        run(IN_W'(256), 8, 0);                // R3 -> ff
        run(IN_W'(255), 8, 0);                // R5 boundary
        run(IN_W'(-1), 8, 0);                 // R4 -> 0
        run({1'b0, {(IN_W-1){1'b1}}}, 32, 0); // R3 at N=OUT_W
        run({1'b1, {(IN_W-1){1'b0}}}, 32, 1); // R2 at N=OUT_W
        run(IN_W'(77), 0, 1);                 // R7 zero width
        run(IN_W'(77), 33, 0);                // R7 too wide
        run(IN_W'(-5), 63, 1);                // R7 max code

        for (int i = 0; i < 3000; i++) begin
            int n;
            bit sm;
            logic [IN_W-1:0] d;
            longint b;
            sm = 1'($urandom);
            n  = ($urandom_range(0, 19) == 0) ? $urandom_range(0, 63) : $urandom_range(1, OUT_W);
            case ($urandom_range(0, 3))
                0: d = {$urandom, $urandom};
                1: d = IN_W'($signed($urandom_range(0, 600)) - 300);
                default: begin
                    if (n >= 1 && n <= OUT_W)
                        b = $urandom_range(0, 1) ? lim_hi(n, sm) : lim_lo(n, sm);
                    else
                        b = 0;
                    d = IN_W'(b + longint'($urandom_range(0, 4)) - 2);
                end
            endcase
            run(d, n, sm);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule